// File: doc/BRIEF.md
# Processor Status Flag Unit

This block keeps the status flags of a small 8-bit processor core: the global interrupt enable (IE), zero (Z), auxiliary carry (AC) and carry (CY). Each cycle the surrounding core presents the outcome of the instruction that is retiring. That outcome can be an arithmetic result together with its bit-3 and bit-7 carry or borrow, a rotate shift-out bit, a bit-operation operand, a decoded EI or DI, an interrupt-acknowledge strobe, or a direct write of the whole flag byte. Each flag has its own update enable. A flag that the instruction does not affect therefore keeps its value.

CY does more than catch arithmetic carries. It takes the bit shifted out by a rotate, and it serves as a one-bit accumulator for bit instructions: move, AND, OR, XOR and invert. IE clears by itself when an interrupt is acknowledged. The block also gates the per-source request lines with the registered IE and the per-source mask bits, and reports whether any request may be accepted.

Top module: `psw_unit`

## Requirements
- R1: After a cycle with `rst_n` low, IE, Z, AC and CY are all 0, `flags_o` is 0 and `irq_accept_o` is 0.
- R2: With `z_we_i` high and no byte write, Z becomes 1 one cycle later if `res_i` is all zeros, and 0 otherwise.
- R3: With `ac_we_i` high and no byte write, AC becomes `res_c3_i` (carry or borrow at bit 3) one cycle later.
- R4: With `cy_op_i` = 1 (arithmetic) and no byte write, CY becomes `res_c7_i` (carry or borrow out of the top bit) one cycle later.
- R5: With `cy_op_i` = 2 (rotate) and no byte write, CY becomes `rot_out_i` one cycle later.
- R6: The bit-accumulator codes of `cy_op_i` give CY = `bit_in_i` for 3 (move), CY & `bit_in_i` for 4, CY | `bit_in_i` for 5, CY ^ `bit_in_i` for 6, and ~CY for 7 (invert, which ignores `bit_in_i`).
- R7: A flag whose enable is inactive keeps its value: `z_we_i` low for Z, `ac_we_i` low for AC, and `cy_op_i` = 0 for CY.
- R8: `ei_i` sets IE and `di_i` clears it, one cycle later. If both are high, DI wins.
- R9: `ack_i` clears IE one cycle later. It wins over `ei_i` and over a byte write that carries IE = 1.
- R10: With `wr_en_i` high, all four flags load from `wr_data_i` in one cycle, using IE = bit 3, Z = bit 2, AC = bit 1 and CY = bit 0. This overrides any per-flag update in the same cycle. Bits 7..4 are ignored.
- R11: `irq_open_o[i]` = IE & `irq_req_i[i]` & ~`irq_mask_i[i]`, where a mask bit of 1 blocks its source. `irq_accept_o` is the OR of `irq_open_o`. Both use the registered IE.
- R12: `flags_o` shows IE, Z, AC and CY at bits 3, 2, 1 and 0, with bits 7..4 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_i | input | DATA_W | Arithmetic result |
| res_c3_i | input | 1 | Carry or borrow at bit 3 |
| res_c7_i | input | 1 | Carry or borrow out of the top bit |
| z_we_i | input | 1 | Update enable for Z |
| ac_we_i | input | 1 | Update enable for AC |
| cy_op_i | input | 3 | CY source and operation select |
| rot_out_i | input | 1 | Bit shifted out by a rotate |
| bit_in_i | input | 1 | Operand of a bit instruction |
| ei_i | input | 1 | Decoded EI |
| di_i | input | 1 | Decoded DI |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| wr_en_i | input | 1 | Whole flag byte write |
| wr_data_i | input | 8 | Flag byte to load |
| irq_req_i | input | N_SRC | Per-source requests |
| irq_mask_i | input | N_SRC | Per-source mask, 1 blocks |
| ie_o | output | 1 | IE flag |
| z_o | output | 1 | Z flag |
| ac_o | output | 1 | AC flag |
| cy_o | output | 1 | CY flag |
| flags_o | output | 8 | Packed flag byte |
| irq_open_o | output | N_SRC | Requests passed by IE and mask |
| irq_accept_o | output | 1 | Some request may be accepted |

## Verification
The assertions assume that only the documented `cy_op_i` codes occur and that the inputs are stable at the clock edge. They also assume that while `rst_n` is low, every update input is held idle, so that no check that spans the first cycle after reset sees a pending update. The bench follows these rules: it changes inputs only on the falling edge and returns every strobe to zero between steps. It applies EI and DI together, and acknowledge together with EI or a write, only in the vectors that test those priorities.

// File: rtl/psw_pkg.sv
// Package: shared types and constants of the status flag unit.
// Assumes: the flag byte is 8 bits wide; the low nibble holds the flags.
package psw_pkg;

    localparam int FLAG_BYTE_W = 8;
    localparam int NUM_FLAGS   = 4;
    localparam int POS_CY      = 0;
    localparam int POS_AC      = 1;
    localparam int POS_Z       = 2;
    localparam int POS_IE      = 3;

    // CY source and operation select
    typedef enum logic [2:0] {
        CY_KEEP   = 3'd0,
        CY_ARITH  = 3'd1,
        CY_ROTATE = 3'd2,
        CY_MOVE   = 3'd3,
        CY_AND    = 3'd4,
        CY_OR     = 3'd5,
        CY_XOR    = 3'd6,
        CY_INVERT = 3'd7
    } cy_op_e;

    typedef struct packed {
        logic ie;
        logic z;
        logic ac;
        logic cy;
    } flags_t;

endpackage

// File: rtl/psw_result_flags.sv
// Module: derives Z and AC candidates from an arithmetic result.
// Assumes: the ALU already folded the add or subtract sense into res_c3.
module psw_result_flags #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              res_c3_i,
    input  logic              z_we_i,
    input  logic              ac_we_i,
    output logic              z_val_o,
    output logic              ac_val_o,
    output logic              z_load_o,
    output logic              ac_load_o
);

    localparam int HALF_W = (DATA_W + 1) / 2;

    logic [1:0] half_any;

    // Detect nonzero bits separately in each half of the result
    generate
        if (DATA_W > 1) begin : g_split
            assign half_any[0] = |res_i[HALF_W-1:0];
            assign half_any[1] = |res_i[DATA_W-1:HALF_W];
        end else begin : g_single
            assign half_any[0] = res_i[0];
            assign half_any[1] = 1'b0;
        end
    endgenerate

    // Zero flag candidate and load strobes
    always_comb begin
        z_val_o   = ~(half_any[0] | half_any[1]);
        ac_val_o  = res_c3_i;
        z_load_o  = z_we_i;
        ac_load_o = ac_we_i;
    end

endmodule

// File: rtl/psw_cy_path.sv
// Module: next value of CY for arithmetic, rotate and bit instructions.
// Assumes: cy_op is a decoded code from psw_pkg::cy_op_e.
module psw_cy_path
    import psw_pkg::*;
(
    input  logic   cy_q_i,
    input  cy_op_e cy_op_i,
    input  logic   carry_i,
    input  logic   rot_bit_i,
    input  logic   bit_in_i,
    output logic   cy_next_o,
    output logic   cy_load_o
);

    // Select the CY source or accumulator operation
    always_comb begin
        cy_load_o = (cy_op_i != CY_KEEP);
        unique case (cy_op_i)
            CY_KEEP:   cy_next_o = cy_q_i;
            CY_ARITH:  cy_next_o = carry_i;
            CY_ROTATE: cy_next_o = rot_bit_i;
            CY_MOVE:   cy_next_o = bit_in_i;
            CY_AND:    cy_next_o = cy_q_i & bit_in_i;
            CY_OR:     cy_next_o = cy_q_i | bit_in_i;
            CY_XOR:    cy_next_o = cy_q_i ^ bit_in_i;
            CY_INVERT: cy_next_o = ~cy_q_i;
            default:   cy_next_o = cy_q_i;
        endcase
    end

endmodule

// File: rtl/psw_ie_ctl.sv
// Module: next value of the global interrupt enable.
// Assumes: priority is acknowledge, then byte write, then DI, then EI.
module psw_ie_ctl (
    input  logic ie_q_i,
    input  logic ei_i,
    input  logic di_i,
    input  logic ack_i,
    input  logic wr_en_i,
    input  logic wr_ie_i,
    output logic ie_next_o
);

    // Resolve the enable sources by fixed priority
    always_comb begin
        if (ack_i)        ie_next_o = 1'b0;
        else if (wr_en_i) ie_next_o = wr_ie_i;
        else if (di_i)    ie_next_o = 1'b0;
        else if (ei_i)    ie_next_o = 1'b1;
        else              ie_next_o = ie_q_i;
    end

endmodule

// File: rtl/psw_irq_gate.sv
// Module: combines IE with per-source masks into an accept signal.
// Assumes: a mask bit of 1 blocks its source.
module psw_irq_gate #(
    parameter int N_SRC = 8
) (
    input  logic             ie_i,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] mask_i,
    output logic [N_SRC-1:0] open_o,
    output logic             accept_o
);

    // One gate per interrupt source
    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            assign open_o[s] = ie_i & req_i[s] & ~mask_i[s];
        end
    endgenerate

    // Any source passing the gate
    assign accept_o = |open_o;

endmodule

// File: rtl/psw_unit.sv
// Module: top of the status flag unit; holds IE, Z, AC and CY.
// Assumes: synchronous active-low reset; one retiring instruction per cycle.
module psw_unit
    import psw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_SRC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] res_i,
    input  logic              res_c3_i,
    input  logic              res_c7_i,
    input  logic              z_we_i,
    input  logic              ac_we_i,
    input  logic [2:0]        cy_op_i,
    input  logic              rot_out_i,
    input  logic              bit_in_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              ack_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_data_i,
    input  logic [N_SRC-1:0]  irq_req_i,
    input  logic [N_SRC-1:0]  irq_mask_i,
    output logic              ie_o,
    output logic              z_o,
    output logic              ac_o,
    output logic              cy_o,
    output logic [7:0]        flags_o,
    output logic [N_SRC-1:0]  irq_open_o,
    output logic              irq_accept_o
);

    flags_t flags_q, flags_d;
    logic   z_val, ac_val, z_load, ac_load;
    logic   cy_next, cy_load, ie_next;
    logic   unused_wr_hi;

    assign unused_wr_hi = ^wr_data_i[FLAG_BYTE_W-1:NUM_FLAGS];

    psw_result_flags #(.DATA_W(DATA_W)) u_res (
        .res_i     (res_i),
        .res_c3_i  (res_c3_i),
        .z_we_i    (z_we_i),
        .ac_we_i   (ac_we_i),
        .z_val_o   (z_val),
        .ac_val_o  (ac_val),
        .z_load_o  (z_load),
        .ac_load_o (ac_load)
    );

    psw_cy_path u_cy (
        .cy_q_i    (flags_q.cy),
        .cy_op_i   (cy_op_e'(cy_op_i)),
        .carry_i   (res_c7_i),
        .rot_bit_i (rot_out_i),
        .bit_in_i  (bit_in_i),
        .cy_next_o (cy_next),
        .cy_load_o (cy_load)
    );

    psw_ie_ctl u_ie (
        .ie_q_i    (flags_q.ie),
        .ei_i      (ei_i),
        .di_i      (di_i),
        .ack_i     (ack_i),
        .wr_en_i   (wr_en_i),
        .wr_ie_i   (wr_data_i[POS_IE]),
        .ie_next_o (ie_next)
    );

    psw_irq_gate #(.N_SRC(N_SRC)) u_gate (
        .ie_i     (flags_q.ie),
        .req_i    (irq_req_i),
        .mask_i   (irq_mask_i),
        .open_o   (irq_open_o),
        .accept_o (irq_accept_o)
    );

    // Next flag state: byte write overrides the per-flag updates
    always_comb begin
        flags_d    = flags_q;
        flags_d.ie = ie_next;
        if (wr_en_i) begin
            flags_d.z  = wr_data_i[POS_Z];
            flags_d.ac = wr_data_i[POS_AC];
            flags_d.cy = wr_data_i[POS_CY];
        end else begin
            if (z_load)  flags_d.z  = z_val;
            if (ac_load) flags_d.ac = ac_val;
            if (cy_load) flags_d.cy = cy_next;
        end
    end

    // Flag register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // Individual flag outputs
    assign ie_o = flags_q.ie;
    assign z_o  = flags_q.z;
    assign ac_o = flags_q.ac;
    assign cy_o = flags_q.cy;

    // Pack the flag byte; unused positions read zero
    generate
        for (genvar b = 0; b < FLAG_BYTE_W; b++) begin : g_pack
            if (b == POS_IE)      begin : g_ie assign flags_o[b] = flags_q.ie; end
            else if (b == POS_Z)  begin : g_z  assign flags_o[b] = flags_q.z;  end
            else if (b == POS_AC) begin : g_ac assign flags_o[b] = flags_q.ac; end
            else if (b == POS_CY) begin : g_cy assign flags_o[b] = flags_q.cy; end
            else                  begin : g_0  assign flags_o[b] = 1'b0;       end
        end
    endgenerate

endmodule

// File: rtl/psw_unit_chk.sv
// Module: assertion checker for psw_unit, attached by bind.
// Assumes: inputs idle during reset and stable at the clock edge.
module psw_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] res_i,
    input logic              res_c3_i,
    input logic              res_c7_i,
    input logic              z_we_i,
    input logic [2:0]        cy_op_i,
    input logic              rot_out_i,
    input logic              ac_we_i,
    input logic              ei_i,
    input logic              di_i,
    input logic              ack_i,
    input logic              wr_en_i,
    input logic [7:0]        wr_data_i,
    input logic              ie_o,
    input logic              z_o,
    input logic              ac_o,
    input logic              cy_o,
    input logic [7:0]        flags_o,
    input logic              irq_accept_o
);

    p_z_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (z_we_i && !wr_en_i) |=> (z_o == ($past(res_i) == '0)));

    p_ac_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_we_i && !wr_en_i) |=> (ac_o == $past(res_c3_i)));

    p_cy_arith_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_op_i == 3'd1 && !wr_en_i) |=> (cy_o == $past(res_c7_i)));

    p_cy_rot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_op_i == 3'd2 && !wr_en_i) |=> (cy_o == $past(rot_out_i)));

    p_cy_invert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_op_i == 3'd7 && !wr_en_i) |=> (cy_o != $past(cy_o)));

    p_z_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!z_we_i && !wr_en_i) |=> $stable(z_o));

    p_cy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_op_i == 3'd0 && !wr_en_i) |=> $stable(cy_o));

    p_ei_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_i && !di_i && !ack_i && !wr_en_i) |=> ie_o);

    p_di_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (di_i && !ack_i && !wr_en_i) |=> !ie_o);

    p_ack_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !ie_o);

    p_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !ack_i) |=> (flags_o[3:0] == $past(wr_data_i[3:0])));

    p_pack_hi_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[7:4] == 4'd0);

    p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_o |-> !irq_accept_o);

endmodule

bind psw_unit psw_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_i        (res_i),
    .res_c3_i     (res_c3_i),
    .res_c7_i     (res_c7_i),
    .z_we_i       (z_we_i),
    .cy_op_i      (cy_op_i),
    .rot_out_i    (rot_out_i),
    .ac_we_i      (ac_we_i),
    .ei_i         (ei_i),
    .di_i         (di_i),
    .ack_i        (ack_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .ie_o         (ie_o),
    .z_o          (z_o),
    .ac_o         (ac_o),
    .cy_o         (cy_o),
    .flags_o      (flags_o),
    .irq_accept_o (irq_accept_o)
);

// File: tb/psw_unit_tb_top.sv
// Bench: table-driven flag updates, then directed reset and gate tests.
module psw_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int N_SRC      = 8;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [7:0] res;
        logic       c3;
        logic       c7;
        logic       zwe;
        logic       acwe;
        logic [2:0] cyop;
        logic       rot;
        logic       bt;
        logic       ei;
        logic       di;
        logic       ack;
        logic       wr;
        logic [7:0] wd;
        logic [3:0] exp;   // {IE, Z, AC, CY}
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,4'b1000}, // R8 EI
        '{8'h00,1'b0,1'b0,1'b1,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'b1100}, // R2 zero
        '{8'h10,1'b1,1'b1,1'b1,1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'b1011}, // R2 R3 R4
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'b1011}, // R7 hold
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'b1010}, // R5 rot 0
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'b1011}, // R5 rot 1
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'b1010}, // R6 move
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd5,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,4'b1011}, // R6 or
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd4,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'b1010}, // R6 and
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd7,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'b1011}, // R6 invert
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd6,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,4'b1010}, // R6 xor
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,4'b0010}, // R8 DI wins
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,4'b0010}, // R9 ack vs EI
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,4'b1010}, // R8 EI
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,4'b0010}, // R9 ack
        '{8'h55,1'b0,1'b0,1'b1,1'b0,3'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h0D,4'b1101}, // R10 override
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h0F,4'b0111}, // R9 ack vs write
        '{8'h00,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'hF0,4'b0000}, // R10 high bits
        '{8'h00,1'b1,1'b0,1'b1,1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'b0110}, // R2 R3 R4
        '{8'h80,1'b0,1'b1,1'b1,1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'b0001}  // R2 R3 R4
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [DATA_W-1:0] res_i;
    logic              res_c3_i, res_c7_i, z_we_i, ac_we_i;
    logic [2:0]        cy_op_i;
    logic              rot_out_i, bit_in_i, ei_i, di_i, ack_i, wr_en_i;
    logic [7:0]        wr_data_i;
    logic [N_SRC-1:0]  irq_req_i, irq_mask_i;
    logic              ie_o, z_o, ac_o, cy_o;
    logic [7:0]        flags_o;
    logic [N_SRC-1:0]  irq_open_o;
    logic              irq_accept_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    psw_unit #(.DATA_W(DATA_W), .N_SRC(N_SRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .res_i(res_i), .res_c3_i(res_c3_i),
        .res_c7_i(res_c7_i), .z_we_i(z_we_i), .ac_we_i(ac_we_i),
        .cy_op_i(cy_op_i), .rot_out_i(rot_out_i), .bit_in_i(bit_in_i),
        .ei_i(ei_i), .di_i(di_i), .ack_i(ack_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .irq_req_i(irq_req_i), .irq_mask_i(irq_mask_i),
        .ie_o(ie_o), .z_o(z_o), .ac_o(ac_o), .cy_o(cy_o), .flags_o(flags_o),
        .irq_open_o(irq_open_o), .irq_accept_o(irq_accept_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        res_i = '0; res_c3_i = 0; res_c7_i = 0; z_we_i = 0; ac_we_i = 0;
        cy_op_i = 3'd0; rot_out_i = 0; bit_in_i = 0; ei_i = 0; di_i = 0;
        ack_i = 0; wr_en_i = 0; wr_data_i = '0;
    endtask

    task automatic write_byte(input logic [7:0] d);
        idle(); wr_en_i = 1; wr_data_i = d;
        @(negedge clk); idle();
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        irq_req_i = '0; irq_mask_i = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 flags after reset", flags_o, 8'h00);
        check("R1 accept after reset", irq_accept_o, 1'b0);

        // Table walk: one vector per cycle, checked on the following falling edge
        for (int v = 0; v < NV; v++) begin
            res_i = VEC[v].res; res_c3_i = VEC[v].c3; res_c7_i = VEC[v].c7;
            z_we_i = VEC[v].zwe; ac_we_i = VEC[v].acwe; cy_op_i = VEC[v].cyop;
            rot_out_i = VEC[v].rot; bit_in_i = VEC[v].bt; ei_i = VEC[v].ei;
            di_i = VEC[v].di; ack_i = VEC[v].ack; wr_en_i = VEC[v].wr;
            wr_data_i = VEC[v].wd;
            @(negedge clk);
            check($sformatf("R12 vector %0d flags_o", v), flags_o, {4'b0, VEC[v].exp});
            check($sformatf("R2-vector %0d z_o R2", v), z_o, VEC[v].exp[2]);
            check($sformatf("vector %0d cy_o R6", v), cy_o, VEC[v].exp[0]);
        end
        idle();

        // R11: gate with IE set, masked then unmasked
        write_byte(8'h08);
        irq_req_i = 8'b0000_0100; irq_mask_i = 8'b0000_0100;
        #1;
        check("R11 masked source blocked", irq_accept_o, 1'b0);
        irq_mask_i = 8'b1111_1011;
        #1;
        check("R11 unmasked source accepted", irq_accept_o, 1'b1);
        check("R11 open vector", irq_open_o, 8'b0000_0100);
        irq_req_i = 8'b1000_0101; irq_mask_i = 8'b0000_0001;
        #1;
        check("R11 open vector mixed", irq_open_o, 8'b1000_0100);

        // R11: DI closes the gate one cycle later
        di_i = 1;
        @(negedge clk); idle();
        check("R11 accept after DI", irq_accept_o, 1'b0);
        check("R11 open after DI", irq_open_o, 8'h00);

        // R7: enables low with active data leave all of Z, AC, CY alone
        write_byte(8'h07);
        res_i = 8'hFF; res_c3_i = 0; res_c7_i = 0; rot_out_i = 0;
        @(negedge clk); idle();
        check("R7 flags held", flags_o, 8'h07);

        // R1: reset mid-run clears everything
        write_byte(8'h0F);
        irq_req_i = 8'h01; irq_mask_i = 8'h00;
        rst_n = 0; @(negedge clk); rst_n = 1;
        check("R1 flags after second reset", flags_o, 8'h00);
        check("R1 accept after second reset", irq_accept_o, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule